// File: doc/BRIEF.md
# Temporal-Silence Coherence Line Controller

This block holds the coherence state of one cache line on an atomic snooping bus and steps it through an invalidation protocol. The protocol has six states: the four usual ones (invalid, shared, exclusive, modified) plus two more.

- **Parked-invalid.** When a sharer loses its copy to another node's ownership request, the line moves to a parked-invalid state instead of plain invalid. The stale copy is kept as the one candidate value the line may later return to.
- **Restored-shared.** A Validate broadcast seen on the bus restores a parked line to the restored-shared state. In that state the line serves local reads, but it stays silent in the shared snoop response when the next ownership request arrives.

On the local side, the processor issues reads and writes, and a separate pulse reports that a store has put the line back to its earlier value. On the bus side, the block watches transactions from other nodes and drives the shared and data-supply responses.

For each ownership request it issues, the block records whether any remote sharer answered. When the line later reverts to its earlier value, it broadcasts a Validate and gives up ownership only if a sharer had answered. Otherwise it stays exclusive and sends nothing. A sharer is a node whose copy has been read since it was restored, which is why a restored-shared line withholds its answer: the answer tells the owner whether its previous Validate was useful.

Each bus request the block issues completes in the cycle it is made, and that cycle's collected shared line is returned on `rsp_shared`. A snooped transaction and a local request cannot both use the line in one cycle. The snoop wins, and the local request is not acknowledged.

Top module: `tsc_line_ctrl`

## Requirements
- R1: After synchronous active-low reset the line state is invalid (code 0), the sharer flag is 0, and no bus request, shared response, data supply, candidate capture or acknowledge is driven.
- R2: The state codes are invalid 0, shared 1, exclusive 2, modified 3, parked-invalid 4 and restored-shared 5, and no other code ever appears. Bus and snoop operations use the codes Read 0, ReadX 1, Upgrade 2 and Validate 3.
- R3: A local read in invalid or parked-invalid issues a Read and enters shared if `rsp_shared` is 1, or exclusive if it is 0, and clears the sharer flag. A local read in restored-shared enters shared with no bus request. Reads in shared, exclusive or modified change nothing.
- R4: A local write issues ReadX from invalid or parked-invalid, or Upgrade from shared or restored-shared, and enters modified, loading the sharer flag from `rsp_shared`. From exclusive it enters modified silently. In modified it changes nothing.
- R5: A shared or restored-shared line snooping ReadX or Upgrade enters parked-invalid and pulses `cand_capture`. A parked-invalid line snooping either stays parked with no capture, so only the first candidate is kept.
- R6: A parked-invalid line snooping Validate enters restored-shared. Validate has no effect in any other state.
- R7: `snp_shared` is driven for a snooped Read in shared, restored-shared, exclusive or modified, and for a snooped ReadX or Upgrade in shared only. It is never driven in invalid or parked-invalid, nor for a restored-shared line on ReadX or Upgrade.
- R8: In exclusive or modified, a snooped Read moves the line to shared, and a snooped ReadX or Upgrade moves it to invalid. `snp_supply` is driven on Read and ReadX, and not on Upgrade.
- R9: A revert pulse in exclusive or modified with the sharer flag set issues a Validate and moves the line to shared.
- R10: With suppression enabled, a revert pulse in exclusive or modified with the sharer flag clear issues nothing and leaves the line in exclusive. A revert pulse in any other state has no effect.
- R11: When `snp_valid` is high, no local request is acknowledged and no bus request is issued. Otherwise `cpu_ack` follows any local request, and write takes precedence over read, which takes precedence over the revert pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cpu_rd | input | 1 | Local read request |
| cpu_wr | input | 1 | Local write request (non-silent store) |
| ts_hit | input | 1 | Pulse: the line has reverted to its earlier value |
| rsp_shared | input | 1 | Collected shared line for this cycle's own bus request |
| snp_valid | input | 1 | A remote transaction is snooped this cycle |
| snp_op | input | 2 | Snooped operation code |
| bus_req_valid | output | 1 | Own bus request this cycle |
| bus_req_op | output | 2 | Own bus request code |
| snp_shared | output | 1 | Shared snoop response |
| snp_supply | output | 1 | This line supplies data to the snooped request |
| cand_capture | output | 1 | Keep the current copy as the revert candidate |
| cpu_ack | output | 1 | Local request accepted this cycle |
| sharer_seen | output | 1 | A remote sharer answered the last ownership request |
| line_state | output | 3 | Current state code |

## Verification
The bench builds the block with its default parameters, with validate suppression enabled. In that configuration every reachable starting condition can be driven through the ports: the six states, plus modified with the sharer flag both set and clear. Each of these starting conditions is met with every local request (once with the shared response 0 and once with 1), the revert pulse, each of the four snooped operations, and a snoop arriving together with local requests. The variant with suppression disabled is not built by the bench.

// File: rtl/tsc_pkg.sv
package tsc_pkg;
   localparam int TSC_ST_W = 3;
   localparam int TSC_OP_W = 2;

   typedef enum logic [TSC_ST_W-1:0] {
      LN_INV  = 3'd0,
      LN_SHR  = 3'd1,
      LN_EXC  = 3'd2,
      LN_MOD  = 3'd3,
      LN_TINV = 3'd4,
      LN_VSHR = 3'd5
   } line_st_e;

   typedef enum logic [TSC_OP_W-1:0] {
      BOP_RD  = 2'd0,
      BOP_RDX = 2'd1,
      BOP_UPG = 2'd2,
      BOP_VAL = 2'd3
   } bus_op_e;
endpackage

// File: rtl/tsc_validate_gate.sv
module tsc_validate_gate #(
   parameter bit SUPPRESS_EN = 1'b1
) (
   input  logic sharer_seen,
   output logic do_validate
);
   generate
      if (SUPPRESS_EN) begin : g_gate
         assign do_validate = sharer_seen;
      end else begin : g_always
         logic unused_sh;
         assign unused_sh   = sharer_seen;
         assign do_validate = 1'b1;
      end
   endgenerate
endmodule

// File: rtl/tsc_snoop_side.sv
module tsc_snoop_side
   import tsc_pkg::*;
(
   input  line_st_e st,
   input  logic     snp_valid,
   input  bus_op_e  op,
   output line_st_e nxt,
   output logic     shared,
   output logic     supply,
   output logic     capture
);
   always_comb begin
      nxt     = st;
      shared  = 1'b0;
      supply  = 1'b0;
      capture = 1'b0;
      if (snp_valid) begin
         case (op)
            BOP_RD: begin
               case (st)
                  LN_MOD, LN_EXC: begin
                     nxt    = LN_SHR;
                     shared = 1'b1;
                     supply = 1'b1;
                  end
                  LN_SHR, LN_VSHR: shared = 1'b1;
                  default: ;
               endcase
            end
            BOP_RDX, BOP_UPG: begin
               case (st)
                  LN_MOD, LN_EXC: begin
                     nxt    = LN_INV;
                     supply = (op == BOP_RDX);
                  end
                  LN_SHR: begin
                     nxt     = LN_TINV;
                     shared  = 1'b1;
                     capture = 1'b1;
                  end
                  LN_VSHR: begin
                     nxt     = LN_TINV;
                     capture = 1'b1;
                  end
                  default: ;
               endcase
            end
            BOP_VAL: begin
               if (st == LN_TINV) nxt = LN_VSHR;
            end
            default: ;
         endcase
      end
   end
endmodule

// File: rtl/tsc_local_side.sv
module tsc_local_side
   import tsc_pkg::*;
(
   input  line_st_e st,
   input  logic     allow,
   input  logic     rd,
   input  logic     wr,
   input  logic     ts,
   input  logic     rsp_shared,
   input  logic     do_validate,
   output line_st_e nxt,
   output logic     req_valid,
   output bus_op_e  req_op,
   output logic     ack,
   output logic     sh_load,
   output logic     sh_val
);
   assign ack = allow & (rd | wr | ts);

   always_comb begin
      nxt       = st;
      req_valid = 1'b0;
      req_op    = BOP_RD;
      sh_load   = 1'b0;
      sh_val    = 1'b0;
      if (allow) begin
         if (wr) begin
            case (st)
               LN_INV, LN_TINV: begin
                  req_valid = 1'b1;
                  req_op    = BOP_RDX;
                  nxt       = LN_MOD;
                  sh_load   = 1'b1;
                  sh_val    = rsp_shared;
               end
               LN_SHR, LN_VSHR: begin
                  req_valid = 1'b1;
                  req_op    = BOP_UPG;
                  nxt       = LN_MOD;
                  sh_load   = 1'b1;
                  sh_val    = rsp_shared;
               end
               LN_EXC: nxt = LN_MOD;
               default: ;
            endcase
         end else if (rd) begin
            case (st)
               LN_INV, LN_TINV: begin
                  req_valid = 1'b1;
                  req_op    = BOP_RD;
                  nxt       = rsp_shared ? LN_SHR : LN_EXC;
                  sh_load   = 1'b1;
               end
               LN_VSHR: nxt = LN_SHR;
               default: ;
            endcase
         end else if (ts) begin
            if (st == LN_MOD || st == LN_EXC) begin
               if (do_validate) begin
                  req_valid = 1'b1;
                  req_op    = BOP_VAL;
                  nxt       = LN_SHR;
               end else begin
                  nxt = LN_EXC;
               end
            end
         end
      end
   end
endmodule

// File: rtl/tsc_line_ctrl.sv
module tsc_line_ctrl
   import tsc_pkg::*;
#(
   parameter int ST_W        = 3,
   parameter int OP_W        = 2,
   parameter bit SUPPRESS_EN = 1'b1
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            cpu_rd,
   input  logic            cpu_wr,
   input  logic            ts_hit,
   input  logic            rsp_shared,
   input  logic            snp_valid,
   input  logic [OP_W-1:0] snp_op,
   output logic            bus_req_valid,
   output logic [OP_W-1:0] bus_req_op,
   output logic            snp_shared,
   output logic            snp_supply,
   output logic            cand_capture,
   output logic            cpu_ack,
   output logic            sharer_seen,
   output logic [ST_W-1:0] line_state
);
   generate
      if (ST_W != TSC_ST_W) begin : g_bad_st_w
         $error("tsc_line_ctrl: ST_W must equal the package state width");
      end
      if (OP_W != TSC_OP_W) begin : g_bad_op_w
         $error("tsc_line_ctrl: OP_W must equal the package op width");
      end
   endgenerate

   line_st_e state_q, nxt_snp, nxt_loc;
   logic     sharer_q;
   logic     do_validate, sh_load, sh_val;
   bus_op_e  req_op;

   tsc_validate_gate #(.SUPPRESS_EN(SUPPRESS_EN)) u_gate (
      .sharer_seen (sharer_q),
      .do_validate (do_validate)
   );

   tsc_snoop_side u_snp (
      .st        (state_q),
      .snp_valid (snp_valid),
      .op        (bus_op_e'(snp_op)),
      .nxt       (nxt_snp),
      .shared    (snp_shared),
      .supply    (snp_supply),
      .capture   (cand_capture)
   );

   tsc_local_side u_loc (
      .st          (state_q),
      .allow       (~snp_valid),
      .rd          (cpu_rd),
      .wr          (cpu_wr),
      .ts          (ts_hit),
      .rsp_shared  (rsp_shared),
      .do_validate (do_validate),
      .nxt         (nxt_loc),
      .req_valid   (bus_req_valid),
      .req_op      (req_op),
      .ack         (cpu_ack),
      .sh_load     (sh_load),
      .sh_val      (sh_val)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q  <= LN_INV;
         sharer_q <= 1'b0;
      end else begin
         state_q <= snp_valid ? nxt_snp : nxt_loc;
         if (sh_load) sharer_q <= sh_val;
      end
   end

   assign bus_req_op  = req_op;
   assign sharer_seen = sharer_q;
   assign line_state  = state_q;
endmodule

// File: rtl/tsc_line_ctrl_chk.sv
module tsc_line_ctrl_chk #(
   parameter int ST_W        = 3,
   parameter int OP_W        = 2,
   parameter bit SUPPRESS_EN = 1'b1
) (
   input logic            clk,
   input logic            rst_n,
   input logic            cpu_wr,
   input logic            snp_valid,
   input logic [OP_W-1:0] snp_op,
   input logic            bus_req_valid,
   input logic [OP_W-1:0] bus_req_op,
   input logic            snp_shared,
   input logic            cand_capture,
   input logic            cpu_ack,
   input logic            sharer_seen,
   input logic [ST_W-1:0] line_state
);
   assert_legal_state_R2: assert property (@(posedge clk) disable iff (!rst_n)
      line_state <= 3'd5);

   assert_vs_withholds_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (snp_valid && line_state == 3'd5 && (snp_op == 2'd1 || snp_op == 2'd2)) |-> !snp_shared);

   assert_invalid_silent_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (line_state == 3'd0 || line_state == 3'd4) |-> !snp_shared);

   assert_capture_parks_R5: assert property (@(posedge clk) disable iff (!rst_n)
      cand_capture |=> line_state == 3'd4);

   assert_validate_restores_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (snp_valid && line_state == 3'd4 && snp_op == 2'd3) |=> line_state == 3'd5);

   assert_validate_shares_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_req_valid && bus_req_op == 2'd3) |=> line_state == 3'd1);

   assert_validate_gated_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_req_valid && bus_req_op == 2'd3) |-> (sharer_seen || !SUPPRESS_EN));

   assert_snoop_first_R11: assert property (@(posedge clk) disable iff (!rst_n)
      snp_valid |-> (!cpu_ack && !bus_req_valid));

   assert_write_owns_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (cpu_ack && cpu_wr) |=> line_state == 3'd3);
endmodule

bind tsc_line_ctrl tsc_line_ctrl_chk #(
   .ST_W(ST_W), .OP_W(OP_W), .SUPPRESS_EN(SUPPRESS_EN)
) u_chk (
   .clk           (clk),
   .rst_n         (rst_n),
   .cpu_wr        (cpu_wr),
   .snp_valid     (snp_valid),
   .snp_op        (snp_op),
   .bus_req_valid (bus_req_valid),
   .bus_req_op    (bus_req_op),
   .snp_shared    (snp_shared),
   .cand_capture  (cand_capture),
   .cpu_ack       (cpu_ack),
   .sharer_seen   (sharer_seen),
   .line_state    (line_state)
);

// File: tb/tb_tsc_line_ctrl.sv
module tb_tsc_line_ctrl;
   logic clk = 1'b0;
   always #2 clk = ~clk;

   logic       rst_n, cpu_rd, cpu_wr, ts_hit, rsp_shared, snp_valid;
   logic [1:0] snp_op, bus_req_op;
   logic       bus_req_valid, snp_shared, snp_supply, cand_capture, cpu_ack, sharer_seen;
   logic [2:0] line_state;

   int n_chk = 0;
   int n_fail = 0;

   tsc_line_ctrl dut (
      .clk(clk), .rst_n(rst_n), .cpu_rd(cpu_rd), .cpu_wr(cpu_wr), .ts_hit(ts_hit),
      .rsp_shared(rsp_shared), .snp_valid(snp_valid), .snp_op(snp_op),
      .bus_req_valid(bus_req_valid), .bus_req_op(bus_req_op), .snp_shared(snp_shared),
      .snp_supply(snp_supply), .cand_capture(cand_capture), .cpu_ack(cpu_ack),
      .sharer_seen(sharer_seen), .line_state(line_state)
   );

   task automatic chk(input bit ok, input string req, input string what,
                      input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   task automatic idle();
      cpu_rd = 0; cpu_wr = 0; ts_hit = 0; rsp_shared = 0; snp_valid = 0; snp_op = 0;
   endtask

   task automatic cyc();
      @(posedge clk); @(negedge clk);
   endtask

   task automatic do_reset();
      idle(); rst_n = 0; cyc(); cyc(); rst_n = 1;
   endtask

   // stimulus: 0 rd/rsp0, 1 rd/rsp1, 2 wr/rsp0, 3 wr/rsp1, 4 revert pulse,
   // 5..8 snoop op 0..3, 9 snoop ReadX together with rd, wr and revert pulse
   task automatic drive(input int s);
      idle();
      case (s)
         0: cpu_rd = 1;
         1: begin cpu_rd = 1; rsp_shared = 1; end
         2: cpu_wr = 1;
         3: begin cpu_wr = 1; rsp_shared = 1; end
         4: ts_hit = 1;
         5, 6, 7, 8: begin snp_valid = 1; snp_op = 2'(s - 5); end
         default: begin snp_valid = 1; snp_op = 2'd1; cpu_rd = 1; cpu_wr = 1; ts_hit = 1; end
      endcase
   endtask

   // starting condition k: 0 I, 1 S, 2 E, 3 M/sharer0, 4 M/sharer1, 5 T, 6 VS
   task automatic goto_start(input int k);
      do_reset();
      case (k)
         1: begin drive(1); cyc(); end
         2: begin drive(0); cyc(); end
         3: begin drive(2); cyc(); end
         4: begin drive(3); cyc(); end
         5: begin drive(1); cyc(); drive(6); cyc(); end
         6: begin drive(1); cyc(); drive(6); cyc(); drive(8); cyc(); end
         default: ;
      endcase
      idle();
   endtask

   // expected behaviour, derived from the requirement list
   task automatic model(input int st, input bit sh, input int s,
                        output int nst, output bit nsh, output bit bv, output int bop,
                        output bit shr, output bit sup, output bit cap, output bit ack);
      bit rsp;
      int op;
      nst = st; nsh = sh; bv = 0; bop = 0; shr = 0; sup = 0; cap = 0; ack = 0;
      rsp = (s == 1 || s == 3);
      if (s >= 5) begin
         op = (s == 9) ? 1 : s - 5;
         if (op == 0) begin
            if (st == 2 || st == 3) begin nst = 1; shr = 1; sup = 1; end
            else if (st == 1 || st == 5) shr = 1;
         end else if (op == 1 || op == 2) begin
            if (st == 2 || st == 3) begin nst = 0; sup = (op == 1); end
            else if (st == 1) begin nst = 4; shr = 1; cap = 1; end
            else if (st == 5) begin nst = 4; cap = 1; end
         end else if (st == 4) nst = 5;
      end else begin
         ack = 1;
         if (s == 2 || s == 3) begin
            if (st == 0 || st == 4) begin bv = 1; bop = 1; nst = 3; nsh = rsp; end
            else if (st == 1 || st == 5) begin bv = 1; bop = 2; nst = 3; nsh = rsp; end
            else if (st == 2) nst = 3;
         end else if (s == 0 || s == 1) begin
            if (st == 0 || st == 4) begin bv = 1; bop = 0; nst = rsp ? 1 : 2; nsh = 0; end
            else if (st == 5) nst = 1;
         end else begin
            if (st == 2 || st == 3) begin
               if (sh) begin bv = 1; bop = 3; nst = 1; end
               else nst = 2;
            end
         end
      end
   endtask

   function automatic string tag(input int s);
      case (s)
         0, 1: return "R3";
         2, 3: return "R4";
         4: return "R9/R10";
         5: return "R7/R8";
         6, 7: return "R5/R7/R8";
         8: return "R6";
         default: return "R11";
      endcase
   endfunction

   task automatic final_report();
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_chk++; n_fail++;
      $display("FAIL watchdog expired actual=0 expected=1");
      final_report();
      $finish;
   end

   initial begin
      int start_st[7] = '{0, 1, 2, 3, 3, 4, 5};
      idle(); rst_n = 0;
      @(negedge clk);
      do_reset();
      // R1: reset state
      chk(line_state == 0, "R1", "state", line_state, 0);
      chk({bus_req_valid, snp_shared, snp_supply, cand_capture, cpu_ack, sharer_seen} == 0,
          "R1", "outputs", {bus_req_valid, snp_shared, snp_supply, cand_capture, cpu_ack, sharer_seen}, 0);

      for (int k = 0; k < 7; k++) begin
         for (int s = 0; s < 10; s++) begin
            int nst, bop, got, exp;
            bit nsh, bv, shr, sup, cap, ack;
            goto_start(k);
            // R2: state encodings reached through the ports
            chk(line_state == 3'(start_st[k]), "R2", "start state", line_state, start_st[k]);
            chk(sharer_seen == (k == 4), "R4", "start sharer", sharer_seen, (k == 4));
            drive(s);
            #1;
            model(start_st[k], (k == 4), s, nst, nsh, bv, shr ? bop : bop, shr, sup, cap, ack);
            got = {bus_req_valid, (bus_req_valid ? bus_req_op : 2'd0), snp_shared, snp_supply, cand_capture, cpu_ack};
            exp = {bv, 2'(bop), shr, sup, cap, ack};
            chk(got == exp, tag(s), $sformatf("outputs start=%0d stim=%0d", k, s), got, exp);
            cyc();
            chk(line_state == 3'(nst), tag(s), $sformatf("next state start=%0d stim=%0d", k, s), line_state, nst);
            chk(sharer_seen == nsh, tag(s), $sformatf("sharer start=%0d stim=%0d", k, s), sharer_seen, nsh);
            idle();
         end
      end
      final_report();
      $finish;
   end
endmodule